// File: doc/BRIEF.md
# Alarm Match and Shared Output Pin Controller

This block watches the running calendar time and raises an alarm when the programmed alarm fields agree with it. There are five alarm fields: seconds, minutes, hours, date and month. Each field can be included in the comparison or left out on its own. When the comparison succeeds on a one-second tick, a sticky alarm flag is set. The flag stays set until software reads the control register.

A single active-low open-drain output is shared by three functions. The first is a 512 Hz calibration clock. The second is a square wave at one of four divider frequencies. The third is the alarm itself. When none of these is selected, the output is released. The block only produces the drive-low enable; the pad and the pull-up are outside it. The time fields come from the timekeeping core in BCD. The divider taps come from its prescaler. A small register port holds the control bits and the five alarm values.

Top module: `alarm_pin_ctl`

## Requirements
- R1: After a synchronous active-low reset, the alarm flag is 0 and the control register reads 0x00. Every alarm register reads 0x80, which means the field is left out of the comparison and its value is 0.
- R2: The alarm registers sit at addresses 1 to 5 (seconds, minutes, hours, date, month), and each one maps to the same 8-bit slice of `cur_time`, starting with seconds at bits 7:0. Bit 7 of an alarm register set to 0 puts the field in the comparison, where its 8 bits must equal {0, value[6:0]}. Bit 7 set to 1 leaves the field out.
- R3: When every alarm register has bit 7 set to 1, every `sec_tick` sets the flag.
- R4: The flag can only become set in the cycle after a `sec_tick` on which all selected fields match. A matching time with no tick leaves the flag at 0.
- R5: Once set, the flag stays set until a read of address 0 (control). That read clears the flag on the next clock edge. If a matching tick arrives in the same cycle as the read, the set wins and the flag stays 1.
- R6: A read of any address other than 0 leaves the flag unchanged.
- R7: Reading address 0 returns bit 7 = alarm mode select, bit 6 = alarm flag, bits 5:4 = square-wave frequency code, bit 3 = alarm enable and bit 2 = calibration enable. Bits 1:0 read as 0. Bit 6 ignores writes.
- R8: With calibration enable = 1, `pin_pull_low` equals the inverse of `div_taps[1]` (the 512 Hz tap), whatever the other control bits are.
- R9: With calibration = 0 and mode select = 0, `pin_pull_low` equals the inverse of `div_taps[code]`. The codes 0, 1, 2 and 3 select the 1 Hz, 512 Hz, 4096 Hz and 32768 Hz taps.
- R10: With calibration = 0, mode select = 1 and alarm enable = 1, `pin_pull_low` equals the alarm flag.
- R11: With calibration = 0, mode select = 1 and alarm enable = 0, `pin_pull_low` is 0 (released).
- R12: Calibration mode does not stop alarm matching: a matching tick still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse after each time update |
| cur_time | input | 40 | BCD time {month, date, hours, minutes, seconds}, 8 bits each |
| div_taps | input | 4 | Divider outputs: 1 Hz, 512 Hz, 4096 Hz, 32768 Hz (bits 0 to 3) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| alarm_flag | output | 1 | Sticky alarm flag |
| pin_pull_low | output | 1 | 1 drives the shared open-drain pin low |

## Verification
The assertions assume the following about the inputs:
- `sec_tick` is a single-cycle pulse.
- `reset` is held low for at least one clock before checking begins.
- The register strobes and `cur_time` change only between clock edges, so a tick and a read in the same cycle see stable data.

The bench follows these rules. It drives every input on the falling edge and raises the tick for exactly one cycle. It holds `reset` low for several cycles. It compares the combinational pin and read-data outputs only after their inputs have settled, in the half cycle before the next rising edge.

// File: rtl/alm_pkg.sv
// Package: shared constants for the alarm/pin controller.
// Assumes an 8-bit register port with the control register at address 0.
package alm_pkg;
    localparam int CTRL_ADDR = 0;
    localparam int CAL_BIT   = 2;
    localparam int AEN_BIT   = 3;
    localparam int FREQ_LSB  = 4;
    localparam int FLAG_BIT  = 6;
    localparam int SEL_BIT   = 7;
    localparam int CAL_TAP   = 1;

    // Output pin function, in priority order
    typedef enum logic [1:0] {
        PIN_CAL   = 2'd0,
        PIN_SQW   = 2'd1,
        PIN_ALARM = 2'd2,
        PIN_OFF   = 2'd3
    } pin_fn_e;
endpackage

// File: rtl/alm_regs.sv
// alm_regs: holds the control bits and the alarm field registers, and
// builds the read data. Assumes the flag lives elsewhere and is shown in
// the control read-back. A read of the control address raises clr_req.
module alm_regs #(
    parameter int NUM_FIELDS = 5,
    parameter int FW         = 8,
    parameter int AW         = 3,
    parameter int SEL_W      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic                     reg_re,
    input  logic [AW-1:0]            reg_addr,
    input  logic [FW-1:0]            reg_wdata,
    input  logic                     flag,
    output logic [FW-1:0]            reg_rdata,
    output logic                     cal_en,
    output logic                     aen,
    output logic                     alm_sel,
    output logic [SEL_W-1:0]         freq_code,
    output logic [NUM_FIELDS*FW-1:0] alarm_flat,
    output logic                     clr_req
);
    import alm_pkg::*;

    localparam logic [FW-1:0] ALM_RST = FW'(1) << (FW - 1);

    logic            ctrl_hit;
    logic [FW-1:0]   alm_q [NUM_FIELDS];

    assign ctrl_hit = (reg_addr == AW'(CTRL_ADDR));
    assign clr_req  = reg_re && ctrl_hit;

    // Control register: written at the control address, flag bit excluded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_en    <= 1'b0;
            aen       <= 1'b0;
            alm_sel   <= 1'b0;
            freq_code <= '0;
        end else if (reg_we && ctrl_hit) begin
            cal_en    <= reg_wdata[CAL_BIT];
            aen       <= reg_wdata[AEN_BIT];
            alm_sel   <= reg_wdata[SEL_BIT];
            freq_code <= reg_wdata[FREQ_LSB +: SEL_W];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_alm
            // Alarm field register gi, at address gi+1
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alm_q[gi] <= ALM_RST;
                else if (reg_we && reg_addr == AW'(gi + 1))
                    alm_q[gi] <= reg_wdata;
            end
            assign alarm_flat[gi*FW +: FW] = alm_q[gi];
        end
    endgenerate

    // Read mux: control image or one alarm field, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        if (ctrl_hit) begin
            reg_rdata[CAL_BIT]             = cal_en;
            reg_rdata[AEN_BIT]             = aen;
            reg_rdata[FREQ_LSB +: SEL_W]   = freq_code;
            reg_rdata[FLAG_BIT]            = flag;
            reg_rdata[SEL_BIT]             = alm_sel;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++)
                if (reg_addr == AW'(i + 1))
                    reg_rdata = alm_q[i];
        end
    end
endmodule

// File: rtl/alm_match.sv
// alm_match: compares each alarm field against the current time field.
// Assumes the MSB of an alarm field is an active-low compare select; a
// selected field needs the time field to equal {0, value[FW-2:0]}.
module alm_match #(
    parameter int NUM_FIELDS = 5,
    parameter int FW         = 8
) (
    input  logic [NUM_FIELDS*FW-1:0] alarm_flat,
    input  logic [NUM_FIELDS*FW-1:0] cur_time,
    output logic                     all_hit
);
    logic [NUM_FIELDS-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_cmp
            logic          skip;
            logic [FW-1:0] want;
            // Field gi: passes when left out or when value equals time
            assign skip    = alarm_flat[gi*FW + FW - 1];
            assign want    = {1'b0, alarm_flat[gi*FW +: FW-1]};
            assign hit[gi] = skip || (want == cur_time[gi*FW +: FW]);
        end
    endgenerate

    assign all_hit = &hit;
endmodule

// File: rtl/alm_flag.sv
// alm_flag: sticky alarm flag. Set on a tick with a full match, cleared
// by a control read; a set in the same cycle wins over the clear.
// Assumes the tick is a single-cycle pulse.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic clr,
    output logic flag_q
);
    // Flag register: set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (tick && hit)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    // R4: a rising flag needs a matching tick one cycle earlier
    a_r4_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(tick) && $past(hit)));

    // R5: a set flag only falls after a control read
    a_r5_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr));
endmodule

// File: rtl/alm_pin_sel.sv
// alm_pin_sel: picks the function of the shared open-drain pin in the
// order calibration, square wave, alarm, released. The output is a
// drive-low enable; a high level on a clock function means released.
module alm_pin_sel #(
    parameter int NUM_TAPS = 4,
    parameter int SEL_W    = 2
) (
    input  logic                cal_en,
    input  logic                alm_sel,
    input  logic                aen,
    input  logic [SEL_W-1:0]    freq_code,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                flag,
    output logic                pull_low
);
    import alm_pkg::*;

    pin_fn_e fn;

    // Function decode by priority
    always_comb begin
        if (cal_en)        fn = PIN_CAL;
        else if (!alm_sel) fn = PIN_SQW;
        else if (aen)      fn = PIN_ALARM;
        else               fn = PIN_OFF;
    end

    // Drive-low enable for the chosen function
    always_comb begin
        case (fn)
            PIN_CAL:   pull_low = !taps[CAL_TAP];
            PIN_SQW:   pull_low = !taps[freq_code];
            PIN_ALARM: pull_low = flag;
            default:   pull_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/alarm_pin_ctl.sv
// alarm_pin_ctl: top of the alarm match and shared output controller.
// Assumes sec_tick is a one-cycle pulse issued after each time update
// and that cur_time holds BCD fields {month, date, hours, min, sec}.
module alarm_pin_ctl #(
    parameter int NUM_FIELDS = 5,
    parameter int FW         = 8,
    parameter int AW         = 3,
    parameter int NUM_TAPS   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sec_tick,
    input  logic [NUM_FIELDS*FW-1:0] cur_time,
    input  logic [NUM_TAPS-1:0]      div_taps,
    input  logic                     reg_we,
    input  logic                     reg_re,
    input  logic [AW-1:0]            reg_addr,
    input  logic [FW-1:0]            reg_wdata,
    output logic [FW-1:0]            reg_rdata,
    output logic                     alarm_flag,
    output logic                     pin_pull_low
);
    localparam int SEL_W = $clog2(NUM_TAPS);

    logic                     cal_en;
    logic                     aen;
    logic                     alm_sel;
    logic [SEL_W-1:0]         freq_code;
    logic [NUM_FIELDS*FW-1:0] alarm_flat;
    logic                     clr_req;
    logic                     all_hit;
    logic [NUM_FIELDS-1:0]    skip_bits;

    alm_regs #(.NUM_FIELDS(NUM_FIELDS), .FW(FW), .AW(AW), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .flag(alarm_flag),
        .reg_rdata(reg_rdata), .cal_en(cal_en), .aen(aen), .alm_sel(alm_sel),
        .freq_code(freq_code), .alarm_flat(alarm_flat), .clr_req(clr_req)
    );

    alm_match #(.NUM_FIELDS(NUM_FIELDS), .FW(FW)) match_i (
        .alarm_flat(alarm_flat), .cur_time(cur_time), .all_hit(all_hit)
    );

    alm_flag flag_i (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(all_hit),
        .clr(clr_req), .flag_q(alarm_flag)
    );

    alm_pin_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) pin_i (
        .cal_en(cal_en), .alm_sel(alm_sel), .aen(aen), .freq_code(freq_code),
        .taps(div_taps), .flag(alarm_flag), .pull_low(pin_pull_low)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FIELDS; gi++) begin : g_skip
            assign skip_bits[gi] = alarm_flat[gi*FW + FW - 1];
        end
    endgenerate

    // R3: with every field left out, each tick sets the flag
    a_r3_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && (&skip_bits)) |=> alarm_flag);

    // R10: in alarm mode the pin follows the sticky flag
    a_r10_alarm_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!cal_en && alm_sel && aen) |-> (pin_pull_low == alarm_flag));
endmodule

// File: tb/alarm_pin_ctl_tb_top.sv
module alarm_pin_ctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [39:0] cur_time = '0;
    logic [3:0]  div_taps = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        alarm_flag;
    logic        pin_pull_low;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] rd_val;

    always #2 clk = ~clk;

    alarm_pin_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cur_time(cur_time),
        .div_taps(div_taps), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_flag(alarm_flag), .pin_pull_low(pin_pull_low)
    );

    // Time 12:34:56, date 15, month 06
    localparam logic [39:0] T0 = 40'h0615123456;
    // {alarm regs (month..seconds), expected flag}
    localparam logic [40:0] VEC [9] = '{
        {40'h8080808080, 1'b1},   // R3 all fields left out
        {40'h8080808056, 1'b1},   // R2 seconds only
        {40'h8080808055, 1'b0},   // R2 seconds differ
        {40'h8080803456, 1'b1},   // R2 sec+min
        {40'h8080133456, 1'b0},   // R2 hours differ
        {40'h8015123456, 1'b1},   // R2 through date
        {40'h0615123456, 1'b1},   // R2 all five
        {40'h0715123456, 1'b0},   // R2 month differs
        {40'h80808034D5, 1'b1}    // R2 seconds left out, value ignored
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_alarms(input logic [39:0] v);
        for (int i = 0; i < 5; i++) wr(3'(i + 1), v[i*8 +: 8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 flag", {7'd0, alarm_flag}, 8'h00);
        check("R1 pin sq 1Hz", {7'd0, pin_pull_low}, 8'h01);
        rd(3'd0, rd_val); check("R1 ctrl", rd_val, 8'h00);
        rd(3'd1, rd_val); check("R1 alarm sec", rd_val, 8'h80);
        rd(3'd5, rd_val); check("R1 alarm mon", rd_val, 8'h80);

        // R2/R3 vector table
        cur_time = T0;
        for (int v = 0; v < 9; v++) begin
            set_alarms(VEC[v][40:1]);
            rd(3'd0, rd_val);
            @(negedge clk);
            tick();
            check($sformatf("R2 vector %0d", v), {7'd0, alarm_flag}, {7'd0, VEC[v][0]});
        end

        // R4 match but no tick
        set_alarms(40'h8080808056);
        rd(3'd0, rd_val);
        repeat (3) @(negedge clk);
        check("R4 no tick", {7'd0, alarm_flag}, 8'h00);

        // R5/R6/R7 hold and clear
        tick();
        repeat (3) @(negedge clk);
        check("R5 held", {7'd0, alarm_flag}, 8'h01);
        rd(3'd2, rd_val);
        check("R6 other read", {7'd0, alarm_flag}, 8'h01);
        rd(3'd0, rd_val);
        check("R7 flag bit", rd_val, 8'h40);
        check("R5 cleared", {7'd0, alarm_flag}, 8'h00);

        // R7 control image, flag bit not writable
        wr(3'd0, 8'hFF);
        rd(3'd0, rd_val);
        check("R7 ctrl image", rd_val, 8'hBC);

        // R5 set wins over clear in the same cycle
        @(negedge clk);
        sec_tick = 1'b1; reg_re = 1'b1; reg_addr = 3'd0;
        @(negedge clk);
        sec_tick = 1'b0; reg_re = 1'b0;
        check("R5 set wins", {7'd0, alarm_flag}, 8'h01);
        rd(3'd0, rd_val);

        // R8 calibration pin, other bits set (0xBC has cal=1)
        @(negedge clk); div_taps = 4'b0010; #1;
        check("R8 cal tap high", {7'd0, pin_pull_low}, 8'h00);
        div_taps = 4'b1101; #1;
        check("R8 cal tap low", {7'd0, pin_pull_low}, 8'h01);

        // R12 matching continues in calibration mode
        tick();
        check("R12 flag in cal", {7'd0, alarm_flag}, 8'h01);
        rd(3'd0, rd_val);

        // R9 square wave, each code
        for (int f = 0; f < 4; f++) begin
            wr(3'd0, 8'(f << 4));
            div_taps = 4'(1 << f); #1;
            check($sformatf("R9 code %0d high", f), {7'd0, pin_pull_low}, 8'h00);
            div_taps = ~4'(1 << f); #1;
            check($sformatf("R9 code %0d low", f), {7'd0, pin_pull_low}, 8'h01);
        end

        // R10 alarm pin
        wr(3'd0, 8'h88);
        @(negedge clk);
        check("R10 idle", {7'd0, pin_pull_low}, 8'h00);
        tick();
        check("R10 asserted", {7'd0, pin_pull_low}, 8'h01);

        // R11 released with flag still set
        wr(3'd0, 8'h80);
        check("R11 flag kept", {7'd0, alarm_flag}, 8'h01);
        check("R11 released", {7'd0, pin_pull_low}, 8'h00);

        // R10 read releases the pin
        wr(3'd0, 8'h88);
        rd(3'd0, rd_val);
        check("R10 released", {7'd0, pin_pull_low}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule